// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This block watches the stream of data memory accesses and raises a debug event when an access touches a programmed watch location. It holds a small set of watchpoints. Each one pairs a word-address value register with a control register. The control register selects which byte lanes of that word count, whether loads, stores or both count, which privilege level counts, and which security world counts. A watchpoint may also be tied to one of a few context-ID slots. Each slot holds an enable, a mode and a context ID. A tied watchpoint fires only when the current context ID equals the slot's ID.

Software programs the registers through a simple write port with a combinational read-back. Accesses arrive on an observation input that is qualified by `acc_valid`. The unit only observes, so it never applies back-pressure: every valid cycle is one access and is always taken. Each matching access produces a one-cycle pulse on `dbg_event` in the following cycle, together with a vector of the watchpoints that matched.

Register map (`reg_addr[3:2]` picks the kind, `reg_addr[1:0]` picks the index): 00 = watch value, 01 = watch control, 10 = slot control (bit 0 enable, bits [3:1] mode), 11 = slot context ID. Writes to an index that is not implemented are dropped, and reads from one return zero.

Top module: `dwm_match_unit`

## Requirements
- R1: A watch value register stores write bits [31:2]. Bits [1:0] always read back as zero. Registers reset to zero.
- R2: A watch control register keeps only bits 0, [4:1], [8:5], [15:14] and [20:16]. All other bits read back as zero. Every field resets to zero, so watchpoints start disabled.
- R3: A hit needs control bit 0 set and `acc_addr[31:2]` equal to the stored word. At least one byte lane n must be set both in `acc_strb` and in control bit 5+n. Lane n is byte offset n in little-endian order. A lane field of 0000 never hits.
- R4: Control [4:3] selects the access kind: 01 = load, 10 = store, 11 = either, 00 = never. An access with both `acc_rd` and `acc_wr` set (a swap) matches 01, 10 and 11. An exclusive store is presented as a store whether or not it succeeds.
- R5: Control [2:1] selects the privilege: 01 = privileged (`acc_priv`=1) only, 10 = user only, 11 = either, 00 = never.
- R6: Control [15:14] selects the world: 00 = either, 01 = non-secure (`acc_secure`=0) only, 10 = secure only, 11 = never.
- R7: When control bit 20 is set, a hit also needs all of the following for the slot whose index is in control [19:16]: the slot is implemented (index < NUM_SLOT), the slot's enable is set, the slot's mode is 3'b011, and the slot's context ID equals `cur_ctx_id`.
- R8: `dbg_event` goes high in the cycle after a valid matching access and stays high for exactly one cycle per access. Without `acc_valid` there is never an event.
- R9: `dbg_wp_hit[i]` is high together with `dbg_event` for each watchpoint i that matched the access.
- R10: A register write takes effect for the access presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select {kind, index} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register |
| acc_valid | input | 1 | An access is observed this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_strb | input | 4 | Byte lanes touched within the word |
| acc_rd | input | 1 | Access reads memory |
| acc_wr | input | 1 | Access writes memory |
| acc_priv | input | 1 | 1 = privileged, 0 = user |
| acc_secure | input | 1 | 1 = secure world |
| cur_ctx_id | input | CID_W | Current context ID |
| dbg_event | output | 1 | One-cycle debug event pulse |
| dbg_wp_hit | output | NUM_WP | Watchpoints that matched |

## Verification
Some properties are checked on every cycle. An event is always preceded by a valid access that had a direction and at least one lane. The event agrees with the hit vector. The value read-back never shows the low address bits, and the control read-back never shows reserved bits. Whether a given access should hit is a different matter, because it depends on the combination of lane, kind, privilege, world and link fields against the stored state. Only the bench's scenarios can show this. The bench runs directed corners (lane field zero, swap, reserved codes, unimplemented or misconfigured slots, write followed by an immediate access) and random traffic against a reference model.

// File: rtl/dwm_pkg.sv
package dwm_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned CTL_EN     = 0;
  localparam int unsigned CTL_PRV_LO = 1;
  localparam int unsigned CTL_DIR_LO = 3;
  localparam int unsigned CTL_LANE_LO = 5;
  localparam int unsigned CTL_WLD_LO = 14;
  localparam int unsigned CTL_LIX_LO = 16;
  localparam int unsigned CTL_LNK    = 20;
  localparam logic [REG_W-1:0] CTL_KEEP = 32'h001F_C1FF;
  localparam logic [2:0] SLOT_MODE_LINK = 3'b011;

  typedef enum logic [1:0] {
    RK_VAL  = 2'b00,
    RK_CTL  = 2'b01,
    RK_SCTL = 2'b10,
    RK_SCID = 2'b11
  } reg_kind_e;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  strb;
    logic        rd;
    logic        wr;
    logic        priv;
    logic        secure;
  } access_t;
endpackage

// File: rtl/dwm_regs.sv
module dwm_regs
  import dwm_pkg::*;
#(
  parameter int unsigned NUM_WP   = 2,
  parameter int unsigned NUM_SLOT = 3,
  parameter int unsigned CID_W    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wen,
  input  logic [3:0]                      addr,
  input  logic [REG_W-1:0]                wdata,
  output logic [REG_W-1:0]                rdata,
  output logic [NUM_WP-1:0][29:0]         wp_word,
  output logic [NUM_WP-1:0][REG_W-1:0]    wp_ctl,
  output logic [NUM_SLOT-1:0]             slot_en,
  output logic [NUM_SLOT-1:0][2:0]        slot_mode,
  output logic [NUM_SLOT-1:0][CID_W-1:0]  slot_cid
);
  reg_kind_e  kind;
  logic [1:0] idx;
  assign kind = reg_kind_e'(addr[3:2]);
  assign idx  = addr[1:0];

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp_word[i] <= '0;
        wp_ctl[i]  <= '0;
      end else if (wen && idx == 2'(i)) begin
        if (kind == RK_VAL) wp_word[i] <= wdata[31:2];
        if (kind == RK_CTL) wp_ctl[i]  <= wdata & CTL_KEEP;
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_en[s]   <= 1'b0;
        slot_mode[s] <= '0;
        slot_cid[s]  <= '0;
      end else if (wen && idx == 2'(s)) begin
        if (kind == RK_SCTL) begin
          slot_en[s]   <= wdata[0];
          slot_mode[s] <= wdata[3:1];
        end
        if (kind == RK_SCID) slot_cid[s] <= wdata[CID_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_WP; i++) begin
      if (idx == 2'(i)) begin
        if (kind == RK_VAL) rdata = {wp_word[i], 2'b00};
        if (kind == RK_CTL) rdata = wp_ctl[i];
      end
    end
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (idx == 2'(s)) begin
        if (kind == RK_SCTL) rdata = {28'd0, slot_mode[s], slot_en[s]};
        if (kind == RK_SCID) rdata = REG_W'(slot_cid[s]);
      end
    end
  end
endmodule

// File: rtl/dwm_wp_cmp.sv
module dwm_wp_cmp
  import dwm_pkg::*;
#(
  parameter int unsigned NUM_SLOT = 3,
  parameter int unsigned CID_W    = 32
) (
  input  access_t                         acc,
  input  logic [CID_W-1:0]                cur_cid,
  input  logic [29:0]                     word,
  input  logic [REG_W-1:0]                ctl,
  input  logic [NUM_SLOT-1:0]             slot_en,
  input  logic [NUM_SLOT-1:0][2:0]        slot_mode,
  input  logic [NUM_SLOT-1:0][CID_W-1:0]  slot_cid,
  output logic                            hit
);
  logic [3:0] lanes;
  logic [1:0] dir_sel, prv_sel, wld_sel;
  logic [3:0] link_ix;
  logic addr_ok, dir_ok, prv_ok, wld_ok, link_ok, unused_ctl;

  assign lanes   = ctl[CTL_LANE_LO +: 4];
  assign dir_sel = ctl[CTL_DIR_LO +: 2];
  assign prv_sel = ctl[CTL_PRV_LO +: 2];
  assign wld_sel = ctl[CTL_WLD_LO +: 2];
  assign link_ix = ctl[CTL_LIX_LO +: 4];
  assign unused_ctl = ^{ctl[31:21], ctl[13:9], acc.addr[1:0]};

  assign addr_ok = (acc.addr[31:2] == word) && ((acc.strb & lanes) != 4'b0000);
  assign dir_ok  = (dir_sel[0] && acc.rd) || (dir_sel[1] && acc.wr);
  assign prv_ok  = acc.priv ? prv_sel[0] : prv_sel[1];

  always_comb begin
    unique case (wld_sel)
      2'b00:   wld_ok = 1'b1;
      2'b01:   wld_ok = !acc.secure;
      2'b10:   wld_ok = acc.secure;
      default: wld_ok = 1'b0;
    endcase
  end

  always_comb begin
    link_ok = !ctl[CTL_LNK];
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (ctl[CTL_LNK] && link_ix == 4'(s))
        link_ok = slot_en[s] && slot_mode[s] == SLOT_MODE_LINK && slot_cid[s] == cur_cid;
    end
  end

  assign hit = ctl[CTL_EN] && addr_ok && dir_ok && prv_ok && wld_ok && link_ok;
endmodule

// File: rtl/dwm_match_unit.sv
module dwm_match_unit
  import dwm_pkg::*;
#(
  parameter int unsigned NUM_WP   = 2,
  parameter int unsigned NUM_SLOT = 3,
  parameter int unsigned CID_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  input  logic [3:0]        acc_strb,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic              acc_priv,
  input  logic              acc_secure,
  input  logic [CID_W-1:0]  cur_ctx_id,
  output logic              dbg_event,
  output logic [NUM_WP-1:0] dbg_wp_hit
);
  logic [NUM_WP-1:0][29:0]        wp_word;
  logic [NUM_WP-1:0][REG_W-1:0]   wp_ctl;
  logic [NUM_SLOT-1:0]            slot_en;
  logic [NUM_SLOT-1:0][2:0]       slot_mode;
  logic [NUM_SLOT-1:0][CID_W-1:0] slot_cid;
  logic [NUM_WP-1:0]              hit_c;
  access_t                        acc;

  assign acc = '{addr: acc_addr, strb: acc_strb, rd: acc_rd, wr: acc_wr,
                 priv: acc_priv, secure: acc_secure};

  dwm_regs #(.NUM_WP(NUM_WP), .NUM_SLOT(NUM_SLOT), .CID_W(CID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .wp_word(wp_word), .wp_ctl(wp_ctl),
    .slot_en(slot_en), .slot_mode(slot_mode), .slot_cid(slot_cid)
  );

  for (genvar i = 0; i < NUM_WP; i++) begin : g_cmp
    dwm_wp_cmp #(.NUM_SLOT(NUM_SLOT), .CID_W(CID_W)) u_cmp (
      .acc(acc), .cur_cid(cur_ctx_id), .word(wp_word[i]), .ctl(wp_ctl[i]),
      .slot_en(slot_en), .slot_mode(slot_mode), .slot_cid(slot_cid),
      .hit(hit_c[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_wp_hit <= '0;
      dbg_event  <= 1'b0;
    end else begin
      dbg_wp_hit <= acc_valid ? hit_c : '0;
      dbg_event  <= acc_valid && (hit_c != '0);
    end
  end
endmodule

// File: rtl/dwm_checker.sv
module dwm_checker #(
  parameter int unsigned NUM_WP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [3:0]        acc_strb,
  input logic [3:0]        reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              dbg_event,
  input logic [NUM_WP-1:0] dbg_wp_hit
);
  a_r8_event_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> $past(acc_valid));
  a_r4_event_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> $past(acc_rd || acc_wr));
  a_r3_event_needs_lane: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> $past(acc_strb) != 4'b0000);
  a_r9_event_agrees_hits: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event == (dbg_wp_hit != '0));
  a_r1_value_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[3:2] == 2'b00 |-> reg_rdata[1:0] == 2'b00);
  a_r2_ctl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[3:2] == 2'b01 |-> (reg_rdata & ~32'h001F_C1FF) == 32'd0);
endmodule

bind dwm_match_unit dwm_checker #(.NUM_WP(NUM_WP)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_rd(acc_rd),
  .acc_wr(acc_wr), .acc_strb(acc_strb), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .dbg_event(dbg_event), .dbg_wp_hit(dbg_wp_hit)
);

// File: tb/dwm_match_unit_tb.sv
module dwm_match_unit_tb;
  localparam int NWP = 2, NSL = 3;
  logic clk = 0, rst_n = 0;
  logic reg_wen = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic acc_valid = 0, acc_rd = 0, acc_wr = 0, acc_priv = 0, acc_secure = 0;
  logic [31:0] acc_addr = 0, cur_ctx_id = 0;
  logic [3:0] acc_strb = 0;
  logic dbg_event;
  logic [NWP-1:0] dbg_wp_hit;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_val [4];
  logic [31:0] m_ctl [4];
  logic [3:0]  m_sctl [4];
  logic [31:0] m_scid [4];

  always #2 clk = ~clk;

  dwm_match_unit u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    int ix = a[1:0];
    reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 0;
    case (a[3:2])
      2'b00: if (ix < NWP) m_val[ix] = {d[31:2], 2'b00};
      2'b01: if (ix < NWP) m_ctl[ix] = d & 32'h001F_C1FF;
      2'b10: if (ix < NSL) m_sctl[ix] = d[3:0];
      default: if (ix < NSL) m_scid[ix] = d;
    endcase
  endtask

  function automatic bit ref_hit(int w);
    logic [31:0] c = m_ctl[w];
    bit ok = c[0];
    int sl = c[19:16];
    if (acc_addr[31:2] != m_val[w][31:2]) ok = 0;
    if ((acc_strb & c[8:5]) == 0) ok = 0;
    if (!((c[3] && acc_rd) || (c[4] && acc_wr))) ok = 0;
    if (acc_priv && !c[1]) ok = 0;
    if (!acc_priv && !c[2]) ok = 0;
    if (c[15:14] == 2'b11) ok = 0;
    if (c[15:14] == 2'b01 && acc_secure) ok = 0;
    if (c[15:14] == 2'b10 && !acc_secure) ok = 0;
    if (c[20]) begin
      if (sl >= NSL) ok = 0;
      else if (!m_sctl[sl][0] || m_sctl[sl][3:1] != 3'b011 || m_scid[sl] != cur_ctx_id) ok = 0;
    end
    return ok;
  endfunction

  task automatic access(string req, logic [31:0] a, logic [3:0] s, bit r, bit w,
                        bit p, bit sec, logic [31:0] cid);
    logic [NWP-1:0] e;
    acc_valid = 1; acc_addr = a; acc_strb = s; acc_rd = r; acc_wr = w;
    acc_priv = p; acc_secure = sec; cur_ctx_id = cid;
    for (int i = 0; i < NWP; i++) e[i] = ref_hit(i);
    @(negedge clk);
    acc_valid = 0;
    chk(req, {31'd0, dbg_event}, {31'd0, |e});
    chk(req, 32'(dbg_wp_hit), 32'(e));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_val[i] = 0; m_ctl[i] = 0; m_sctl[i] = 0; m_scid[i] = 0;
    end
    void'($urandom(32'h1F2E3D));
    repeat (3) @(negedge clk);
    chk("R8 reset", {31'd0, dbg_event}, 0);
    rst_n = 1;
    @(negedge clk);
    reg_addr = 4'b0100; #0.1 chk("R2 reset ctl", reg_rdata, 0);
    reg_addr = 4'b0000; #0.1 chk("R1 reset val", reg_rdata, 0);
    wr(4'b0000, 32'h0000_1007);
    reg_addr = 4'b0000; #0.1 chk("R1 low bits", reg_rdata, 32'h0000_1004);
    wr(4'b0100, 32'hFFFF_FFFF);
    reg_addr = 4'b0100; #0.1 chk("R2 mask", reg_rdata, 32'h001F_C1FF);
    wr(4'b0011, 32'hFFFF_FFFF);
    reg_addr = 4'b0011; #0.1 chk("R1 bad index", reg_rdata, 0);
    // R3: lane 2 only on word 0x1004, accesses in either order of bytes
    wr(4'b0100, 32'h0000_0000 | (4'b0100 << 5) | (2'b11 << 3) | (2'b11 << 1) | 1);
    access("R3 lane2 hit", 32'h1006, 4'b0100, 1, 0, 1, 0, 0);
    access("R3 lane0 miss", 32'h1004, 4'b0001, 1, 0, 1, 0, 0);
    access("R3 other word", 32'h1008, 4'b1111, 1, 0, 1, 0, 0);
    access("R3 wide hit", 32'h1004, 4'b1111, 0, 1, 0, 1, 0);
    wr(4'b0100, (2'b11 << 3) | (2'b11 << 1) | 1);
    access("R3 lanes zero", 32'h1004, 4'b1111, 1, 1, 1, 0, 0);
    // R4: store-only, swap counts
    wr(4'b0100, (4'hF << 5) | (2'b10 << 3) | (2'b11 << 1) | 1);
    access("R4 load vs store-only", 32'h1004, 4'b0001, 1, 0, 1, 0, 0);
    access("R4 swap", 32'h1004, 4'b0001, 1, 1, 1, 0, 0);
    wr(4'b0100, (4'hF << 5) | (2'b00 << 3) | (2'b11 << 1) | 1);
    access("R4 reserved dir", 32'h1004, 4'b0001, 1, 1, 1, 0, 0);
    // R5/R6
    wr(4'b0100, (4'hF << 5) | (2'b11 << 3) | (2'b10 << 1) | 1);
    access("R5 user-only priv", 32'h1004, 4'b0001, 1, 0, 1, 0, 0);
    access("R5 user-only user", 32'h1004, 4'b0001, 1, 0, 0, 0, 0);
    wr(4'b0100, (2'b11 << 14) | (4'hF << 5) | (2'b11 << 3) | (2'b11 << 1) | 1);
    access("R6 reserved world", 32'h1004, 4'b0001, 1, 0, 0, 1, 0);
    wr(4'b0100, (2'b01 << 14) | (4'hF << 5) | (2'b11 << 3) | (2'b11 << 1) | 1);
    access("R6 nonsecure only", 32'h1004, 4'b0001, 1, 0, 0, 1, 0);
    access("R6 nonsecure ok", 32'h1004, 4'b0001, 1, 0, 0, 0, 0);
    // R7 linking
    wr(4'b1001, 32'h7); wr(4'b1101, 32'h55);
    wr(4'b0100, (1 << 20) | (1 << 16) | (4'hF << 5) | (2'b11 << 3) | (2'b11 << 1) | 1);
    access("R7 link match", 32'h1004, 4'b0001, 1, 0, 0, 0, 32'h55);
    access("R7 link cid miss", 32'h1004, 4'b0001, 1, 0, 0, 0, 32'h56);
    wr(4'b1001, 32'h5);
    access("R7 bad mode", 32'h1004, 4'b0001, 1, 0, 0, 0, 32'h55);
    wr(4'b0100, (1 << 20) | (3 << 16) | (4'hF << 5) | (2'b11 << 3) | (2'b11 << 1) | 1);
    access("R7 unimpl slot", 32'h1004, 4'b0001, 1, 0, 0, 0, 0);
    // R10: write then immediate access
    wr(4'b0100, (4'hF << 5) | (2'b11 << 3) | (2'b11 << 1) | 1);
    access("R10 immediate", 32'h1004, 4'b0001, 1, 0, 0, 0, 0);
    // R8 one pulse: idle cycle afterwards
    @(negedge clk);
    chk("R8 single pulse", {31'd0, dbg_event}, 0);
    // random traffic (R3-R9)
    for (int n = 0; n < 4000; n++) begin
      int k = $urandom_range(0, 9);
      if (k < 2) begin
        logic [31:0] d = $urandom & 32'h001F_C1FF;
        d[0] = ($urandom_range(0, 3) != 0);
        d[19:16] = 4'($urandom_range(0, 4));
        wr({2'b01, 2'($urandom_range(0, 1))}, d);
      end else if (k == 2) begin
        wr({2'b00, 2'($urandom_range(0, 1))}, 32'h1000 + 4 * $urandom_range(0, 3));
      end else if (k == 3) begin
        wr({1'b1, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 2))},
           ($urandom_range(0, 1) != 0) ? 32'h7 : 32'($urandom_range(0, 15)));
        if ($urandom_range(0, 1) != 0) wr({2'b11, 2'($urandom_range(0, 2))}, 32'($urandom_range(0, 2)));
      end else begin
        access("R9 random", 32'h1000 + $urandom_range(0, 15), 4'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               32'($urandom_range(0, 2)));
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule